// File: doc/BRIEF.md
# Four-Entry Replacement Tracker with Selectable Policy

This block is a small, fully associative tag store that models replacement decisions and keeps no data. Each entry holds a block identifier and a valid flag. A caller presents at most one reference identifier per cycle. The block compares it against every valid entry and reports a hit or a miss one cycle later. On a miss it installs the identifier.

A one-bit policy input chooses how a victim is picked once every entry is occupied. In first-in-first-out mode the victim is the oldest installed entry. In least-recently-used mode it is the entry that has gone longest without being referenced. Empty entries are always filled before any victim is chosen.

Two saturating counters, one for hits and one for misses, let the caller measure the hit ratio over a trace. This makes the block useful for comparing the two policies on a given reference stream.

Top module: `repl_tracker`

## Requirements
- R1: While rst_ni is low, all entries become empty, the age state and insertion pointer clear, both counters read 0, and hit_o and miss_o are low.
- R2: A reference with ref_valid_i high at a rising edge produces, after that edge, exactly one of hit_o (identifier matches a valid entry) or miss_o (no match). Both outputs are low after an edge where ref_valid_i is low.
- R3: On a miss the lowest-index empty entry is filled, and nothing is evicted while an empty entry exists. After four distinct misses from reset, those four identifiers all hit.
- R4: With policy_lru_i = 0 (FIFO), a miss on a full store replaces the entry installed longest ago, and hits do not alter that order.
- R5: With policy_lru_i = 1 (LRU), a miss on a full store replaces the entry whose last reference (hit or install) is oldest.
- R6: With policy_lru_i = 0, the trace A B C A D E A D C F from reset yields 3 hits and 7 misses on the counters.
- R7: With policy_lru_i = 1, the same trace from reset yields 4 hits and 7-1=6 misses on the counters.
- R8: hit_count_o and miss_count_o each increase by one per hit or miss reported and hold at 2^CNT_W-1 instead of wrapping.
- R9: Cycles with ref_valid_i low change neither the counters nor the stored contents or replacement order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| policy_lru_i | input | 1 | 0 selects FIFO, 1 selects LRU replacement |
| ref_valid_i | input | 1 | A reference is presented this cycle |
| ref_id_i | input | ID_W | Block identifier of the reference |
| hit_o | output | 1 | Previous-cycle reference hit |
| miss_o | output | 1 | Previous-cycle reference missed |
| hit_count_o | output | CNT_W | Saturating hit count |
| miss_count_o | output | CNT_W | Saturating miss count |

## Verification
The assertions assume that reset is applied before the first clock edge and that ref_id_i carries known values whenever ref_valid_i is high. They also assume that policy_lru_i changes only while no reference is in flight. The stimulus meets these assumptions by changing the policy only during a reset pulse and by driving every reference fully. An exhaustive sweep covers all five-reference sequences over five identifiers in both modes. Each outcome is compared against a recency-list model held in the bench.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic {
    POL_FIFO = 1'b0,
    POL_LRU  = 1'b1
  } repl_policy_e;
endpackage

// File: rtl/repl_match.sv
module repl_match #(
  parameter int N = 4,
  parameter int ID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]           valid_i,
  input  logic [N-1:0][ID_W-1:0] tag_i,
  input  logic [ID_W-1:0]        id_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       hit_idx_o,
  output logic                   full_o,
  output logic [IDX_W-1:0]       free_idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tag_i[g] == id_i);
  end

  always_comb begin
    hit_idx_o  = '0;
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i])    hit_idx_o  = IDX_W'(i);
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign hit_o  = |match;
  assign full_o = &valid_i;
endmodule

// File: rtl/repl_victim.sv
module repl_victim
  import repl_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  repl_policy_e              policy_i,
  input  logic                      full_i,
  input  logic [IDX_W-1:0]          free_idx_i,
  input  logic [N-1:0][IDX_W-1:0]   age_i,
  input  logic [IDX_W-1:0]          fifo_ptr_i,
  output logic [IDX_W-1:0]          victim_o
);
  logic [N-1:0]     oldest;
  logic [IDX_W-1:0] lru_idx;

  for (genvar g = 0; g < N; g++) begin : g_old
    assign oldest[g] = (age_i[g] == '1);
  end

  always_comb begin
    lru_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (oldest[i]) lru_idx = IDX_W'(i);
  end

  always_comb begin
    if (!full_i)                victim_o = free_idx_i;
    else if (policy_i == POL_LRU) victim_o = lru_idx;
    else                        victim_o = fifo_ptr_i;
  end
endmodule

// File: rtl/repl_entry.sv
module repl_entry #(
  parameter int ID_W = 8,
  parameter int AGE_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_i,
  input  logic             hit_i,
  input  logic             install_i,
  input  logic             sel_i,
  input  logic [AGE_W-1:0] ref_age_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             valid_o,
  output logic [ID_W-1:0]  tag_o,
  output logic [AGE_W-1:0] age_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      age_o   <= '0;
    end else if (miss_i) begin
      if (install_i) begin
        valid_o <= 1'b1;
        tag_o   <= id_i;
        age_o   <= '0;
      end else if (valid_o && age_o != '1) begin
        age_o <= age_o + AGE_W'(1);
      end
    end else if (hit_i) begin
      // only entries more recent than the referenced one move back
      if (sel_i)                             age_o <= '0;
      else if (valid_o && age_o < ref_age_i) age_o <= age_o + AGE_W'(1);
    end
  end
endmodule

// File: rtl/repl_sat_cnt.sv
module repl_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     count_o <= '0;
    else if (inc_i && count_o != '1) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/repl_tracker.sv
module repl_tracker
  import repl_pkg::*;
#(
  parameter int N = 4,
  parameter int ID_W = 8,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             policy_lru_i,
  input  logic             ref_valid_i,
  input  logic [ID_W-1:0]  ref_id_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] miss_count_o
);
  logic [N-1:0]             valid;
  logic [N-1:0][ID_W-1:0]   tag;
  logic [N-1:0][IDX_W-1:0]  age;
  logic                     lookup_hit, full;
  logic [IDX_W-1:0]         hit_idx, free_idx, victim, fifo_ptr;
  logic                     ref_hit, ref_miss;
  logic [IDX_W-1:0]         ref_age;
  repl_policy_e             policy;

  assign policy   = repl_policy_e'(policy_lru_i);
  assign ref_hit  = ref_valid_i && lookup_hit;
  assign ref_miss = ref_valid_i && !lookup_hit;
  assign ref_age  = age[hit_idx];

  repl_match #(.N(N), .ID_W(ID_W)) i_match (
    .valid_i(valid), .tag_i(tag), .id_i(ref_id_i),
    .hit_o(lookup_hit), .hit_idx_o(hit_idx),
    .full_o(full), .free_idx_o(free_idx)
  );

  repl_victim #(.N(N)) i_victim (
    .policy_i(policy), .full_i(full), .free_idx_i(free_idx),
    .age_i(age), .fifo_ptr_i(fifo_ptr), .victim_o(victim)
  );

  for (genvar g = 0; g < N; g++) begin : g_entry
    repl_entry #(.ID_W(ID_W), .AGE_W(IDX_W)) i_entry (
      .clk_i, .rst_ni,
      .miss_i(ref_miss), .hit_i(ref_hit),
      .install_i(victim == IDX_W'(g)), .sel_i(hit_idx == IDX_W'(g)),
      .ref_age_i(ref_age), .id_i(ref_id_i),
      .valid_o(valid[g]), .tag_o(tag[g]), .age_o(age[g])
    );
  end

  // pointer moves only on true replacement; fills run 0..N-1 in order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               fifo_ptr <= '0;
    else if (ref_miss && full) fifo_ptr <= fifo_ptr + IDX_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
    end else begin
      hit_o  <= ref_hit;
      miss_o <= ref_miss;
    end
  end

  repl_sat_cnt #(.W(CNT_W)) i_hit_cnt (
    .clk_i, .rst_ni, .inc_i(ref_hit), .count_o(hit_count_o)
  );

  repl_sat_cnt #(.W(CNT_W)) i_miss_cnt (
    .clk_i, .rst_ni, .inc_i(ref_miss), .count_o(miss_count_o)
  );
endmodule

// File: rtl/repl_tracker_chk.sv
module repl_tracker_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ref_valid_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] miss_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_one_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_i |=> (hit_o ^ miss_o));

  assert_no_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> (!hit_o && !miss_o));

  assert_hit_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(hit_count_o) != CNT_MAX) |->
      hit_count_o == $past(hit_count_o) + CNT_W'(1));

  assert_miss_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && $past(miss_count_o) != CNT_MAX) |->
      miss_count_o == $past(miss_count_o) + CNT_W'(1));

  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_count_o) == CNT_MAX) |-> hit_count_o == CNT_MAX);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> ($stable(hit_count_o) && $stable(miss_count_o)));
endmodule

bind repl_tracker repl_tracker_chk #(.CNT_W(CNT_W)) i_repl_tracker_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_valid_i(ref_valid_i),
  .hit_o(hit_o), .miss_o(miss_o),
  .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
);

// File: tb/test_repl_tracker.sv
module test_repl_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8;
  localparam int CNT_W = 16;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0, policy_lru = 1'b0, ref_valid = 1'b0;
  logic [ID_W-1:0] ref_id = '0;
  logic hit, miss;
  logic [CNT_W-1:0] hit_cnt, miss_cnt;
  int checks = 0, errors = 0;
  int m_list[4];
  int m_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  repl_tracker #(.N(4), .ID_W(ID_W), .CNT_W(CNT_W)) i_repl_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .policy_lru_i(policy_lru),
    .ref_valid_i(ref_valid), .ref_id_i(ref_id),
    .hit_o(hit), .miss_o(miss), .hit_count_o(hit_cnt), .miss_count_o(miss_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // recency-list model: front is the next victim
  function automatic bit model_ref(int id, bit lru);
    int f = -1;
    for (int i = 0; i < m_cnt; i++) if (m_list[i] == id) f = i;
    if (f >= 0) begin
      if (lru) begin
        for (int i = f; i < m_cnt - 1; i++) m_list[i] = m_list[i+1];
        m_list[m_cnt-1] = id;
      end
      return 1'b1;
    end
    if (m_cnt < 4) begin
      m_list[m_cnt] = id;
      m_cnt++;
    end else begin
      for (int i = 0; i < 3; i++) m_list[i] = m_list[i+1];
      m_list[3] = id;
    end
    return 1'b0;
  endfunction

  task automatic do_reset(input bit lru);
    ref_valid = 1'b0;
    rst_ni = 1'b0;
    policy_lru = lru;
    m_cnt = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // called at a negedge; result sampled at the next negedge
  task automatic do_ref(input int id, input bit exp_hit, input string req);
    ref_valid = 1'b1;
    ref_id = ID_W'(id);
    @(negedge clk);
    check(hit == exp_hit && miss == !exp_hit, req, {hit, miss}, {exp_hit, !exp_hit});
  endtask

  task automatic idle(input int n);
    ref_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_trace(input bit lru);
    int tr[10] = '{1, 2, 3, 1, 4, 5, 1, 4, 3, 6};
    do_reset(lru);
    for (int i = 0; i < 10; i++) do_ref(tr[i], model_ref(tr[i], lru), lru ? "R7" : "R6");
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    check(hit_cnt == 0 && miss_cnt == 0 && !hit && !miss, "R1", hit_cnt + miss_cnt, 0);
    rst_ni = 1'b1;

    // R3 fill before evict, both policies
    for (int p = 0; p < 2; p++) begin
      do_reset(p[0]);
      for (int i = 1; i <= 4; i++) do_ref(i, 1'b0, "R3 fill miss");
      for (int i = 1; i <= 4; i++) do_ref(i, 1'b1, "R3 filled hit");
      idle(1);
    end

    // R4 FIFO: hit on 1 does not save it
    do_reset(1'b0);
    for (int i = 1; i <= 4; i++) do_ref(i, 1'b0, "R4");
    do_ref(1, 1'b1, "R4");
    do_ref(5, 1'b0, "R4");
    do_ref(2, 1'b1, "R4 second-oldest kept");
    do_ref(1, 1'b0, "R4 oldest evicted");
    idle(1);

    // R5 LRU: hit on 1 protects it, 2 goes
    do_reset(1'b1);
    for (int i = 1; i <= 4; i++) do_ref(i, 1'b0, "R5");
    do_ref(1, 1'b1, "R5");
    do_ref(5, 1'b0, "R5");
    do_ref(1, 1'b1, "R5 recent kept");
    do_ref(2, 1'b0, "R5 lru evicted");
    idle(1);

    // R6/R7 reference trace
    run_trace(1'b0);
    check(hit_cnt == 3, "R6 hits", hit_cnt, 3);
    check(miss_cnt == 7, "R6 misses", miss_cnt, 7);
    run_trace(1'b1);
    check(hit_cnt == 4, "R7 hits", hit_cnt, 4);
    check(miss_cnt == 6, "R7 misses", miss_cnt, 6);

    // R9 idle changes nothing: counters held, contents and order intact
    idle(5);
    check(!hit && !miss, "R9 outputs idle", {hit, miss}, 0);
    check(hit_cnt == 4 && miss_cnt == 6, "R9 counters held", hit_cnt, 4);
    do_ref(6, model_ref(6, 1'b1), "R9 contents");
    do_ref(2, model_ref(2, 1'b1), "R9 order");
    do_ref(4, model_ref(4, 1'b1), "R9 order");
    idle(1);

    // exhaustive: all length-5 sequences over 5 ids, both policies
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 3125; s++) begin
        int v = s;
        do_reset(p[0]);
        for (int k = 0; k < 5; k++) begin
          int id = (v % 5) + 10;
          v = v / 5;
          do_ref(id, model_ref(id, p[0]), p[0] ? "R5 sweep" : "R4 sweep");
        end
        idle(1);
      end
    end

    // R8 saturation
    do_reset(1'b0);
    ref_valid = 1'b1;
    ref_id = ID_W'(7);
    repeat (CMAX) @(negedge clk);
    check(hit_cnt == CMAX - 1 && miss_cnt == 1, "R8 before limit", hit_cnt, CMAX - 1);
    @(negedge clk);
    check(hit_cnt == CMAX, "R8 at limit", hit_cnt, CMAX);
    @(negedge clk);
    check(hit_cnt == CMAX && hit, "R8 no wrap", hit_cnt, CMAX);
    check(miss_cnt == 1, "R8 miss count", miss_cnt, 1);
    idle(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule